// File: doc/BRIEF.md
# Immediate-Add Unit with Arithmetic Status Word

This block is the add-immediate slice of an integer execution unit. It owns a small file of data registers (eight by default, each `DATA_W` bits wide). When the execute strobe is high, it adds a small two's-complement constant to the register picked by the index input. The sum goes back into that same register, and the status word is rebuilt from the result.

The status word holds five flags: result-is-zero, result-is-negative, carry-out, signed overflow, and a sticky overflow that remembers any overflow since it was last cleared. The carry and overflow flags each have a duplicate bit that always takes the same value on an add. Software can load the whole status word through a write port and sees the live word on the status output. Any register can be read through a combinational read port.

Top module: `addimm_alu`

## Requirements
- R1: On a rising clock edge with `exeStb` high, the register chosen by `regSel` takes its old value plus `immVal`, which is sign-extended from 7 bits and summed modulo 2^DATA_W. All other registers keep their values.
- R2: After an add, status bit 0 is 1 exactly when the result is all zeros, and status bit 1 equals the result's most significant bit.
- R3: After an add, status bit 12 holds the unsigned carry out of the most significant bit of the sum.
- R4: After an add, status bit 24 is 1 when the add caused a signed overflow and 0 when it did not.
- R5: Status bit 25 is set by any add that overflows. It stays set through later adds without overflow and is cleared only by a status write or by reset.
- R6: After an add, status bit 2 equals status bit 12 and status bit 3 equals status bit 24.
- R7: An add with `immVal` = 0 leaves the register unchanged and clears bits 12, 24, 2 and 3.
- R8: On a rising edge with `statWrEn` high, the status word loads `statWrData` masked to bits {0,1,2,3,12,24,25}. Every other status bit always reads 0.
- R9: When `statWrEn` and `exeStb` are both high on the same edge, the status word takes the masked write data. The selected register is still updated with the sum.
- R10: A rising edge with `rst` high clears every register and the whole status word. Reset takes priority over all other inputs.
- R11: On an edge with `exeStb` and `statWrEn` both low, no register and no status bit changes.
- R12: `rdData` always shows the current contents of the register selected by `rdSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| exeStb | input | 1 | Perform an add-immediate this cycle |
| regSel | input | $clog2(NUM_REGS) | Index of the register to add into |
| immVal | input | 7 | Two's-complement immediate |
| statWrEn | input | 1 | Load the status word from `statWrData` |
| statWrData | input | 32 | Data for a status write |
| rdSel | input | $clog2(NUM_REGS) | Read port register index |
| rdData | output | DATA_W | Contents of the register at `rdSel` |
| statusOut | output | 32 | Current status word |

## Verification
The checker assumes `rst` is high for at least one edge before any check matters. It also assumes each input is stable around the clock edge: the flag-versus-result properties compare the status word with the read port one cycle after an add, and only when `rdSel` then points at the register that was just written.

The bench drives every input at the falling edge and sweeps `rdSel` over all registers inside the low half-period. This keeps the inputs legal and exposes every register for the property that relates flags to the result.

To reach the signed overflow boundaries with only 7-bit steps, the bench builds the unit at 16 bits. It then climbs a register to the largest positive value and crosses it in both directions.

// File: rtl/addimm_pkg.sv
package addimm_pkg;
  localparam int STAT_W   = 32;
  localparam int IMM_W    = 7;
  localparam int POS_ZERO = 0;
  localparam int POS_NEG  = 1;
  localparam int POS_CDUP = 2;
  localparam int POS_VDUP = 3;
  localparam int POS_CARRY = 12;
  localparam int POS_OVF  = 24;
  localparam int POS_STKY = 25;

  localparam logic [STAT_W-1:0] STAT_MASK =
      (STAT_W'(1) << POS_ZERO) | (STAT_W'(1) << POS_NEG)  |
      (STAT_W'(1) << POS_CDUP) | (STAT_W'(1) << POS_VDUP) |
      (STAT_W'(1) << POS_CARRY) | (STAT_W'(1) << POS_OVF) |
      (STAT_W'(1) << POS_STKY);

  typedef struct packed {
    logic clrAll;
    logic regWr;
    logic flagUpd;
    logic statLoad;
  } aluStrobes_t;
endpackage

// File: rtl/addimm_ctrl.sv
module addimm_ctrl
  import addimm_pkg::*;
(
  input  logic        rst,
  input  logic        exeStb,
  input  logic        statWrEn,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.clrAll   = rst;
    strobes.regWr    = !rst && exeStb;
    strobes.statLoad = !rst && statWrEn;
    strobes.flagUpd  = !rst && exeStb && !statWrEn;
  end
endmodule

// File: rtl/addimm_adder.sv
module addimm_adder #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 7
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] sum,
  output logic              carryOut,
  output logic              ovf
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] extImm;
  logic [DATA_W:0]   wideSum;

  assign extImm   = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign wideSum  = {1'b0, opA} + {1'b0, extImm};
  assign sum      = wideSum[DATA_W-1:0];
  assign carryOut = wideSum[DATA_W];
  assign ovf      = (opA[DATA_W-1] == extImm[DATA_W-1]) &&
                    (sum[DATA_W-1] != opA[DATA_W-1]);
endmodule

// File: rtl/addimm_datapath.sv
module addimm_datapath
  import addimm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  aluStrobes_t       strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [STAT_W-1:0] statWrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] statusWord
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] sumVal;
  logic              carryOut;
  logic              ovf;
  logic [STAT_W-1:0] flagWord;

  assign opA    = regFile[wrIdx];
  assign rdData = regFile[rdIdx];

  addimm_adder #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_adder (
    .opA      (opA),
    .imm      (immVal),
    .sum      (sumVal),
    .carryOut (carryOut),
    .ovf      (ovf)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (strobes.clrAll)
        regFile[g] <= '0;
      else if (strobes.regWr && (wrIdx == IDX_W'(g)))
        regFile[g] <= sumVal;
    end
  end

  always_comb begin
    flagWord            = '0;
    flagWord[POS_ZERO]  = (sumVal == '0);
    flagWord[POS_NEG]   = sumVal[DATA_W-1];
    flagWord[POS_CARRY] = carryOut;
    flagWord[POS_CDUP]  = carryOut;
    flagWord[POS_OVF]   = ovf;
    flagWord[POS_VDUP]  = ovf;
    flagWord[POS_STKY]  = statusWord[POS_STKY] | ovf;
  end

  always_ff @(posedge clk) begin
    if (strobes.clrAll)
      statusWord <= '0;
    else if (strobes.statLoad)
      statusWord <= statWrData & STAT_MASK;
    else if (strobes.flagUpd)
      statusWord <= flagWord;
  end
endmodule

// File: rtl/addimm_alu.sv
module addimm_alu
  import addimm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exeStb,
  input  logic [IDX_W-1:0]  regSel,
  input  logic [6:0]        immVal,
  input  logic              statWrEn,
  input  logic [31:0]       statWrData,
  input  logic [IDX_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [31:0]       statusOut
);
  aluStrobes_t strobes;

  addimm_ctrl u_ctrl (
    .rst      (rst),
    .exeStb   (exeStb),
    .statWrEn (statWrEn),
    .strobes  (strobes)
  );

  addimm_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .wrIdx      (regSel),
    .immVal     (immVal),
    .statWrData (statWrData),
    .rdIdx      (rdSel),
    .rdData     (rdData),
    .statusWord (statusOut)
  );
endmodule

// File: rtl/addimm_alu_chk.sv
module addimm_alu_chk
  import addimm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              exeStb,
  input logic [IDX_W-1:0]  regSel,
  input logic [6:0]        immVal,
  input logic              statWrEn,
  input logic [31:0]       statWrData,
  input logic [IDX_W-1:0]  rdSel,
  input logic [DATA_W-1:0] rdData,
  input logic [31:0]       statusOut
);
  logic addOnly;
  assign addOnly = exeStb && !statWrEn;

  // R10
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (statusOut == '0));

  // R2
  a_r2_zero_neg: assert property (@(posedge clk) disable iff (rst)
    addOnly |=> (rdSel != $past(regSel)) ||
                ((statusOut[POS_ZERO] == (rdData == '0)) &&
                 (statusOut[POS_NEG] == rdData[DATA_W-1])));

  // R5
  a_r5_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (statusOut[POS_STKY] && !statWrEn) |=> statusOut[POS_STKY]);

  a_r5_sticky_follows: assert property (@(posedge clk) disable iff (rst)
    addOnly |=> (!statusOut[POS_OVF] || statusOut[POS_STKY]));

  // R6
  a_r6_mirrors: assert property (@(posedge clk) disable iff (rst)
    addOnly |=> ((statusOut[POS_CDUP] == statusOut[POS_CARRY]) &&
                 (statusOut[POS_VDUP] == statusOut[POS_OVF])));

  // R7
  a_r7_zero_imm: assert property (@(posedge clk) disable iff (rst)
    (addOnly && immVal == '0) |=> (!statusOut[POS_CARRY] && !statusOut[POS_OVF]));

  // R8
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    statWrEn |=> (statusOut == ($past(statWrData) & STAT_MASK)));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusOut & ~STAT_MASK) == '0));

  // R11
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    (!exeStb && !statWrEn) |=> $stable(statusOut));
endmodule

bind addimm_alu addimm_alu_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exeStb     (exeStb),
  .regSel     (regSel),
  .immVal     (immVal),
  .statWrEn   (statWrEn),
  .statWrData (statWrData),
  .rdSel      (rdSel),
  .rdData     (rdData),
  .statusOut  (statusOut)
);

// File: tb/addimm_alu_bench.sv
`timescale 1ns/1ps
module addimm_alu_bench;
  localparam int W  = 16;
  localparam int NR = 8;
  localparam logic [31:0] MASK = 32'h0300_100F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exeStb = 1'b0;
  logic [2:0]  regSel = '0;
  logic [6:0]  immVal = '0;
  logic        statWrEn = 1'b0;
  logic [31:0] statWrData = '0;
  logic [2:0]  rdSel = '0;
  logic [W-1:0] rdData;
  logic [31:0] statusOut;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [W-1:0] mReg [NR];
  logic [31:0]  mStat;

  always #4 clk = ~clk;

  addimm_alu #(.DATA_W(W), .NUM_REGS(NR)) u_addimm_alu (
    .clk(clk), .rst(rst), .exeStb(exeStb), .regSel(regSel), .immVal(immVal),
    .statWrEn(statWrEn), .statWrData(statWrData), .rdSel(rdSel),
    .rdData(rdData), .statusOut(statusOut)
  );

  task automatic modelEdge();
    longint span, sa, si, ua, us, ls, uSum;
    logic [W-1:0] res;
    logic [31:0] f;
    span = longint'(1) <<< W;
    if (rst) begin
      for (int i = 0; i < NR; i++) mReg[i] = '0;
      mStat = '0;
      return;
    end
    f = mStat;
    if (exeStb) begin
      ua = longint'(mReg[regSel]);
      sa = (ua >= span / 2) ? ua - span : ua;
      si = longint'($signed(immVal));
      us = (si < 0) ? si + span : si;
      ls = sa + si;
      uSum = ua + us;
      res = W'(uSum % span);
      mReg[regSel] = res;
      f = '0;
      f[0]  = (res == '0);
      f[1]  = res[W-1];
      f[12] = (uSum >= span);
      f[2]  = f[12];
      f[24] = (ls >= span / 2) || (ls < -(span / 2));
      f[3]  = f[24];
      f[25] = mStat[25] | f[24];
    end
    if (statWrEn) mStat = statWrData & MASK;
    else if (exeStb) mStat = f;
  endtask

  task automatic check(input string tag);
    testCnt++;
    if (statusOut !== mStat) begin
      failCnt++;
      $display("FAIL %s status actual=%h expected=%h", tag, statusOut, mStat);
    end
    for (int i = 0; i < NR; i++) begin
      rdSel = 3'(i);
      #0.1;
      testCnt++;
      if (rdData !== mReg[i]) begin
        failCnt++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, rdData, mReg[i]);
      end
    end
  endtask

  task automatic step(input bit ex, input [2:0] sel, input [6:0] imm,
                      input bit sw, input [31:0] sd, input string tag);
    exeStb = ex; regSel = sel; immVal = imm; statWrEn = sw; statWrData = sd;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    exeStb = 1'b0; statWrEn = 1'b0;
    check(tag);
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    rst = 1'b0;
    check(tag);
  endtask

  task automatic climb(input [2:0] sel, input [W-1:0] target);
    while (mReg[sel] != target) begin
      int diff = int'(target) - int'(mReg[sel]);
      if (diff > 63) diff = 63;
      if (diff < -64) diff = -64;
      step(1'b1, sel, 7'(diff), 1'b0, 32'h0, "R1");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset("R10");
    // zero/negative/carry on register 0: 0 +0, +1, -1, -1, +1
    step(1, 0, 7'd0,   0, 0, "R7");
    step(1, 0, 7'd1,   0, 0, "R2");
    step(1, 0, 7'h7F,  0, 0, "R3");
    step(1, 0, 7'h7F,  0, 0, "R2");
    step(1, 0, 7'd1,   0, 0, "R3");
    // all-ones +1 on register 5
    step(1, 5, 7'h7F,  0, 0, "R2");
    step(1, 5, 7'd1,   0, 0, "R3");
    step(1, 5, 7'h7F,  0, 0, "R2");
    step(1, 5, 7'd0,   0, 0, "R7");
    // overflow boundaries on register 3
    climb(3, W'(16'h7FFF));
    step(1, 3, 7'd1,   0, 0, "R4");
    step(1, 3, 7'h7F,  0, 0, "R4");
    step(1, 3, 7'h7F,  0, 0, "R5");
    step(1, 3, 7'd0,   0, 0, "R6");
    step(0, 3, 7'd5,   0, 0, "R11");
    step(0, 0, 7'd0,   1, 32'h0, "R8");
    step(0, 0, 7'd0,   1, 32'hFFFF_FFFF, "R8");
    step(1, 2, 7'd9,   0, 0, "R6");
    // negative-side overflow: 0x8000 - 1
    climb(4, W'(16'h7FFF));
    step(1, 4, 7'd1,   0, 0, "R4");
    step(0, 0, 7'd0,   1, 32'h0, "R5");
    step(1, 4, 7'h7F,  0, 0, "R4");
    step(1, 4, 7'd3,   1, 32'h0000_1001, "R9");
    step(1, 6, 7'd20,  0, 0, "R12");
    step(1, 4, 7'd1,   1, 32'h0, "R9");
    for (int k = 0; k < 400; k++) begin
      bit ex = ($urandom % 4) != 0;
      bit sw = ($urandom % 10) == 0;
      step(ex, 3'($urandom), 7'($urandom), sw, $urandom, "R1");
    end
    exeStb = 1'b1; statWrEn = 1'b1; statWrData = 32'hFFFF_FFFF;
    doReset("R10");
    step(0, 0, 7'd0, 0, 0, "R11");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule